// File: doc/BRIEF.md
# Read-to-clear interrupt status byte

This block holds the one-byte interrupt cause register of a paravirtual device that signals its host over a legacy level-sensitive interrupt wire. Two single-cycle event pulses feed it. One reports queue activity and the other reports a change in device configuration. Each pulse sets its own sticky bit, and the bit stays set until software reads the byte. The read returns the byte and empties it in the same access, so the read itself acknowledges the interrupt.

From the pending bits the block derives two outputs. The first is the interrupt-pending flag that the configuration space shows in its status word. The second is the level interrupt pin. Both are held low while message-signalled interrupts are in use. The pin alone is also gated by a mask input. Events keep latching in every mode, so pending causes survive a switch between signalling modes.

Top module: `intx_isr_status`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), the status byte reads 0x00 and both `pci_int_status_o` and `intx_o` are low.
- R2: A pulse on `queue_evt_i` sets status bit 0, and a pulse on `cfg_evt_i` sets status bit 1, at the clock edge that ends the pulse cycle.
- R3: Status bits 7 down to 2 are reserved. They always read as zero and nothing sets them.
- R4: While `rd_en_i` is high, `rd_data_o` shows the current status byte in that cycle. While `rd_en_i` is low, `rd_data_o` is 0x00. The clock edge that ends a read cycle clears the whole byte.
- R5: With `msix_en_i` low, `pci_int_status_o` equals the OR of all status bits.
- R6: With `msix_en_i` low and `intx_mask_i` low, `intx_o` is high exactly while any status bit is set, and it falls after the read that clears the byte.
- R7: With `msix_en_i` high, `pci_int_status_o` and `intx_o` stay low whatever the status byte holds.
- R8: An event pulse in the same cycle as a read is not lost. The read returns the old byte, and the event's bit is set once the clear has taken effect.
- R9: A set bit is sticky. Further pulses on its input change nothing, and the bit stays set until a read.
- R10: `intx_mask_i` forces only `intx_o` low. The status bits and `pci_int_status_o` keep reflecting pending events.
- R11: With `msix_en_i` high, events still set their bits and reads still clear the byte. Bits left pending raise both outputs once `msix_en_i` returns low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| queue_evt_i | input | 1 | Single-cycle pulse for queue activity |
| cfg_evt_i | input | 1 | Single-cycle pulse for a configuration change |
| rd_en_i | input | 1 | Read strobe for the status byte, one cycle per access |
| rd_data_o | output | 8 | Status byte during a read, zero otherwise |
| msix_en_i | input | 1 | Message-signalled interrupt mode is active |
| intx_mask_i | input | 1 | Masks the level interrupt pin |
| pci_int_status_o | output | 1 | Interrupt-pending flag for the configuration status word |
| intx_o | output | 1 | Level-sensitive interrupt output |

## Verification
The critical collision is a clearing read that lands in the same cycle as a new event pulse. The clear and the set then act on the same register at one edge. The bench provokes this in two ways. In one case it raises the event for a bit that is already pending during the read. In the other case it raises the event for a different bit during the read. The scoreboard checks that the read returns the old byte, and a follow-up read checks that the new event's bit is the only one left.

// File: rtl/isr_pkg.sv
`timescale 1ns/1ps
// Package: shared sizes and bit positions for the interrupt status byte.
// Assumes the event bits occupy the low positions and the rest are reserved.
package isr_pkg;
    localparam int STATUS_W = 8;   // width of the status byte
    localparam int EVT_N    = 2;   // number of event sources

    // Bit positions that software decodes (order matters)
    typedef enum int {
        QUEUE_BIT = 0,
        CFG_BIT   = 1
    } isr_bit_e;
endpackage

// File: rtl/isr_sticky_bits.sv
`timescale 1ns/1ps
// Module: isr_sticky_bits
// Holds the sticky cause bits. Each event pulse sets its bit. A clear request
// empties the whole field at the same edge, but a coincident event wins for
// its own bit, so no event is lost. Reserved bits are tied to zero.
// Assumes: synchronous active-low reset; events are single-cycle pulses.
module isr_sticky_bits #(
    parameter int W = isr_pkg::STATUS_W,
    parameter int N = isr_pkg::EVT_N
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt_i,
    input  logic         clr_i,
    output logic [W-1:0] status_o
);
    genvar gi;
    generate
        for (gi = 0; gi < W; gi++) begin : g_bit
            if (gi < N) begin : g_live
                logic bit_q;
                // Set on event; clear on read unless an event arrives now
                always_ff @(posedge clk) begin
                    if (!rst_n)
                        bit_q <= 1'b0;
                    else if (evt_i[gi])
                        bit_q <= 1'b1;
                    else if (clr_i)
                        bit_q <= 1'b0;
                end
                assign status_o[gi] = bit_q;
            end else begin : g_rsvd
                assign status_o[gi] = 1'b0;
            end
        end
    endgenerate
endmodule

// File: rtl/isr_read_port.sv
`timescale 1ns/1ps
// Module: isr_read_port
// Presents the status byte on the read bus for the duration of a read strobe
// and turns the strobe into a clear request for the sticky bits.
// Assumes: one strobe cycle per access; the bus is zero when idle.
module isr_read_port #(
    parameter int W = isr_pkg::STATUS_W
) (
    input  logic         rd_en_i,
    input  logic [W-1:0] status_i,
    output logic [W-1:0] rd_data_o,
    output logic         clr_o
);
    // Drive the bus only during a read
    always_comb begin
        rd_data_o = rd_en_i ? status_i : '0;
    end

    // Each read acknowledges every pending cause
    always_comb begin
        clr_o = rd_en_i;
    end
endmodule

// File: rtl/isr_irq_gate.sv
`timescale 1ns/1ps
// Module: isr_irq_gate
// Derives the interrupt-pending flag and the level interrupt pin from the
// status byte. Message-signalled mode silences both; the mask affects only
// the pin. Assumes the status input is already registered.
module isr_irq_gate #(
    parameter int W = isr_pkg::STATUS_W
) (
    input  logic [W-1:0] status_i,
    input  logic         msix_en_i,
    input  logic         intx_mask_i,
    output logic         int_status_o,
    output logic         intx_o
);
    logic any_pending;

    // Reduce the whole field, reserved bits included
    always_comb begin
        any_pending = |status_i;
    end

    // Pending flag is meaningful only in level-interrupt mode
    always_comb begin
        int_status_o = any_pending & ~msix_en_i;
    end

    // Pin follows the flag unless masked
    always_comb begin
        intx_o = int_status_o & ~intx_mask_i;
    end
endmodule

// File: rtl/intx_isr_status.sv
`timescale 1ns/1ps
// Module: intx_isr_status (top)
// Read-to-clear interrupt cause byte with level interrupt generation.
// Assumes: synchronous active-low reset; single-cycle event and read strobes.
module intx_isr_status #(
    parameter int STATUS_W = isr_pkg::STATUS_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                queue_evt_i,
    input  logic                cfg_evt_i,
    input  logic                rd_en_i,
    output logic [STATUS_W-1:0] rd_data_o,
    input  logic                msix_en_i,
    input  logic                intx_mask_i,
    output logic                pci_int_status_o,
    output logic                intx_o
);
    import isr_pkg::*;

    localparam int EVT_W = EVT_N;

    logic [EVT_W-1:0]    evt_vec;
    logic [STATUS_W-1:0] status_q;
    logic                rd_clr;

    // Gather the event pulses at their decoded bit positions
    always_comb begin
        evt_vec            = '0;
        evt_vec[QUEUE_BIT] = queue_evt_i;
        evt_vec[CFG_BIT]   = cfg_evt_i;
    end

    isr_sticky_bits #(.W(STATUS_W), .N(EVT_W)) u_bits (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_i    (evt_vec),
        .clr_i    (rd_clr),
        .status_o (status_q)
    );

    isr_read_port #(.W(STATUS_W)) u_rd (
        .rd_en_i   (rd_en_i),
        .status_i  (status_q),
        .rd_data_o (rd_data_o),
        .clr_o     (rd_clr)
    );

    isr_irq_gate #(.W(STATUS_W)) u_gate (
        .status_i     (status_q),
        .msix_en_i    (msix_en_i),
        .intx_mask_i  (intx_mask_i),
        .int_status_o (pci_int_status_o),
        .intx_o       (intx_o)
    );
endmodule

// File: rtl/isr_status_chk.sv
`timescale 1ns/1ps
// Module: isr_status_chk
// Property checker for intx_isr_status, attached by bind below.
module isr_status_chk #(
    parameter int W = isr_pkg::STATUS_W,
    parameter int N = isr_pkg::EVT_N
) (
    input logic         clk,
    input logic         rst_n,
    input logic         queue_evt_i,
    input logic         cfg_evt_i,
    input logic         rd_en_i,
    input logic [W-1:0] rd_data_o,
    input logic         msix_en_i,
    input logic         intx_mask_i,
    input logic         pci_int_status_o,
    input logic         intx_o,
    input logic [W-1:0] status_q
);
    p_queue_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        queue_evt_i |=> status_q[0]);
    p_cfg_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_evt_i |=> status_q[1]);
    p_reserved_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        status_q[W-1:N] == '0);
    p_clear_on_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && !queue_evt_i && !cfg_evt_i) |=> status_q == '0);
    p_read_shows_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_i |-> rd_data_o == status_q);
    p_pending_or_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !msix_en_i |-> pci_int_status_o == (|status_q));
    p_pin_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!msix_en_i && !intx_mask_i) |-> intx_o == (|status_q));
    p_msix_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        msix_en_i |-> (!intx_o && !pci_int_status_o));
    p_keep_event_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && queue_evt_i) |=> status_q[0]);
    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q[1] && !rd_en_i) |=> status_q[1]);
    p_mask_pin_r10: assert property (@(posedge clk) disable iff (!rst_n)
        intx_mask_i |-> !intx_o);
endmodule

bind intx_isr_status isr_status_chk #(.W(STATUS_W), .N(isr_pkg::EVT_N)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .queue_evt_i      (queue_evt_i),
    .cfg_evt_i        (cfg_evt_i),
    .rd_en_i          (rd_en_i),
    .rd_data_o        (rd_data_o),
    .msix_en_i        (msix_en_i),
    .intx_mask_i      (intx_mask_i),
    .pci_int_status_o (pci_int_status_o),
    .intx_o           (intx_o),
    .status_q         (status_q)
);

// File: tb/intx_isr_status_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes expected read bytes, the monitor pops
// and compares them at the falling edge of every read cycle.
module intx_isr_status_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       q_evt = 1'b0, c_evt = 1'b0, rd = 1'b0;
    logic       msix = 1'b0, mask = 1'b0;
    logic [7:0] rd_data;
    logic       pci, intx;

    int         errors = 0;
    int         checks = 0;
    logic [7:0] model = 8'h00;
    logic [7:0] exp_q[$];
    string      rd_tag = "R4";
    bit         finished = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    intx_isr_status u_intx_isr_status (
        .clk              (clk),
        .rst_n            (rst_n),
        .queue_evt_i      (q_evt),
        .cfg_evt_i        (c_evt),
        .rd_en_i          (rd),
        .rd_data_o        (rd_data),
        .msix_en_i        (msix),
        .intx_mask_i      (mask),
        .pci_int_status_o (pci),
        .intx_o           (intx)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // Compare both interrupt outputs with the values the requirements give
    task automatic check_lines(input string tag);
        logic exp_pci;
        exp_pci = !msix && (model != 8'h00);
        check({tag, " pci"}, {7'b0, pci}, {7'b0, exp_pci});
        check({tag, " intx"}, {7'b0, intx}, {7'b0, exp_pci && !mask});
    endtask

    // One bus cycle; starts just after a rising edge, ends just after the next
    task automatic step(input logic eq, input logic ec, input logic erd);
        logic [7:0] nxt;
        q_evt = eq; c_evt = ec; rd = erd;
        if (erd) exp_q.push_back(model);
        nxt = (erd ? 8'h00 : model) | {6'b0, ec, eq};
        @(posedge clk);
        model = nxt;
        #1;
        q_evt = 1'b0; c_evt = 1'b0; rd = 1'b0;
    endtask

    // Monitor: judge every read in the middle of its cycle
    always @(negedge clk) begin
        if (rd && rst_n && !finished) begin
            if (exp_q.size() == 0) begin
                errors++; checks++;
                $display("FAIL %s: actual=%02h expected=none", rd_tag, rd_data);
            end else begin
                check(rd_tag, rd_data, exp_q.pop_front());
            end
            check("R3 reserved", {2'b0, rd_data[7:2]}, 8'h00);
        end
    end

    initial begin
        #(200000 * 20);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        model = 8'h00;
        check_lines("R1 reset");
        rd_tag = "R1 reset read"; step(0, 0, 1);

        // R2 / R5 / R6: queue event
        step(1, 0, 0);
        check_lines("R2 queue R5 R6");
        #5 check("R4 idle bus", rd_data, 8'h00);
        rd_tag = "R4 read queue"; step(0, 0, 1);
        check_lines("R6 cleared");
        // R2: config event
        step(0, 1, 0);
        check_lines("R2 cfg");
        rd_tag = "R2 read cfg"; step(0, 0, 1);
        // both bits together
        step(1, 1, 0);
        rd_tag = "R3 read both"; step(0, 0, 1);

        // R9: sticky, repeated pulses
        step(1, 0, 0); step(1, 0, 0); step(0, 0, 0); step(1, 0, 0);
        check_lines("R9 sticky");
        rd_tag = "R9 read"; step(0, 0, 1);
        rd_tag = "R9 reread"; step(0, 0, 1);

        // R8: same-cycle event and read
        step(1, 0, 0);
        rd_tag = "R8 same bit"; step(1, 0, 1);
        check_lines("R8 kept");
        rd_tag = "R8 other bit"; step(0, 1, 1);
        rd_tag = "R8 after"; step(0, 0, 1);

        // R10: mask only gates the pin
        mask = 1'b1;
        step(0, 1, 0);
        check_lines("R10 masked");
        check("R10 pci", {7'b0, pci}, 8'h01);
        mask = 1'b0; #1;
        check_lines("R6 unmask");
        rd_tag = "R10 read"; step(0, 0, 1);

        // R7 / R11: message-signalled mode
        msix = 1'b1;
        step(1, 0, 0);
        check_lines("R7 msix");
        rd_tag = "R11 msix read"; step(0, 0, 1);
        step(0, 1, 0);
        check_lines("R7 msix pending");
        msix = 1'b0; #1;
        check_lines("R11 back to level");
        check("R11 intx", {7'b0, intx}, 8'h01);
        rd_tag = "R11 read"; step(0, 0, 1);

        // R1: reset with pending bits
        step(1, 1, 0);
        rst_n = 1'b0;
        @(posedge clk); #1;
        model = 8'h00;
        check_lines("R1 mid reset");
        rst_n = 1'b1;
        rd_tag = "R1 read after reset"; step(0, 0, 1);

        check("R4 queue drained", 8'(exp_q.size()), 8'h00);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule